// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of byte transfers prepared by software, so the processor does not have to step in for each byte. Software loads up to sixteen entries over a small word-addressed register bus. Each entry holds a byte to send, a one-bit command that says whether chip select stays asserted after that entry, and a slot that receives the byte clocked in on MISO. Software then programs the first and last entry numbers and sets an enable bit. The block sends the entries in order and frees the enable bit when the run ends. It then raises a completion flag, which software clears by writing zero.

Chip select can be kept asserted past the end of a run in two ways. A per-run control bit asks for it, or a lock bit holds the frame until software clears it. Either way, a transfer longer than sixteen bytes can be split into several runs that together form one SPI frame. The serial clock comes from the system clock through a programmable divider. Data is sent MSB first in mode 0.

Top module: `spiq_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1 and `spi_sclk` is 0. The control, status, start pointer, end pointer and divider registers all read 0. `spi_sclk` stays 0 whenever no run is active.
- R2: The register map is word addressed. Entry e (0..15) has its transmit byte at word 2e (read/write) and its received byte at word 2e+1 (read only). Its command word is at 0x20+e, where bit 0 is the continue bit. The other registers are: 0x30 start pointer (bits 3:0), 0x31 end pointer (bits 3:0), 0x32 control (bit 0 enable, bit 1 hold-after-run), 0x33 status (bit 0 done), 0x34 lock (bit 0), 0x35 divider (bits 7:0).
- R3: A run processes the entries from the start pointer up to and including the end pointer, in increasing order. The entry number wraps from 15 to 0.
- R4: Each entry sends 8 bits in mode 0. MOSI changes on the falling edge of SCLK and MISO is sampled on the rising edge. Bits go MSB first. Each SCLK half period lasts divider+1 system clocks. The 8 sampled bits are stored in the entry's received-byte word, first bit in bit 7.
- R5: After an entry whose continue bit is 0, chip select goes high before the next entry of the run starts. After an entry whose continue bit is 1, chip select stays low into the next entry.
- R6: After the last entry, chip select stays low only if that entry's continue bit is 1 and either hold-after-run or lock is set. Otherwise chip select goes high. A run that starts while chip select is still held adds no new falling edge of chip select.
- R7: When chip select is held low after a run, writing lock with bit 0 equal to 0 drives `spi_cs_n` high at the clock edge that takes the write.
- R8: When a run ends, enable and hold-after-run both return to 0 and the done bit is set, all at the same clock edge.
- R9: Writing the status register with bit 0 equal to 0 clears done. Writing bit 0 equal to 1 has no effect. When a clear and a run completion fall on the same edge, done ends up set.
- R10: While enable is 1, writes to the transmit bytes, command words, pointers, divider and control are ignored.
- R11: For a one-entry run that starts with chip select high, done is set exactly 17*(divider+1)+1 clock edges after the edge that takes the enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
Two events can land on the same edge: software clearing the done bit, and the sequencer setting it at the end of a run. The bench starts a one-entry run with a known divider and works out the exact completion edge from R11. It checks that done is still 0 one cycle earlier, then lands a status write of zero on that very edge. The result is judged by reading the status back as 1 and the control register as 0. A second plain clear then brings the flag to 0.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
    localparam int Q_DEPTH = 16;
    localparam int PTR_W   = $clog2(Q_DEPTH);
    localparam int BYTE_W  = 8;
    localparam int BIT_W   = $clog2(BYTE_W);
    localparam int DIV_W   = 8;
    localparam int ADDR_W  = 7;

    localparam logic [ADDR_W-1:0] A_START = 7'h30;
    localparam logic [ADDR_W-1:0] A_END   = 7'h31;
    localparam logic [ADDR_W-1:0] A_CTRL  = 7'h32;
    localparam logic [ADDR_W-1:0] A_STAT  = 7'h33;
    localparam logic [ADDR_W-1:0] A_LOCK  = 7'h34;
    localparam logic [ADDR_W-1:0] A_DIV   = 7'h35;

    typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_LAUNCH, PH_XFER, PH_GAP} phase_e;
    typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} shst_e;

    typedef struct packed {
        phase_e             st;
        logic               en;
        logic               cont_after;
        logic               done;
        logic               lock;
        logic               cs_act;
        logic [PTR_W-1:0]   sptr;
        logic [PTR_W-1:0]   eptr;
        logic [PTR_W-1:0]   cur;
        logic [DIV_W-1:0]   div;
        logic [DIV_W-1:0]   cnt;
    } ctl_t;

    typedef struct packed {
        shst_e              st;
        logic [DIV_W-1:0]   cnt;
        logic [BIT_W-1:0]   bitn;
        logic [BYTE_W-1:0]  tsr;
        logic [BYTE_W-1:0]  rsr;
        logic               sclk;
    } sh_t;
endpackage

// File: rtl/spiq_regfile.sv
module spiq_regfile #(
    parameter int DEPTH    = 16,
    parameter int WIDTH    = 8,
    parameter int RD_PORTS = 1,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [AW-1:0]                    waddr,
    input  logic [WIDTH-1:0]                 wdata,
    input  logic [RD_PORTS-1:0][AW-1:0]      raddr,
    output logic [RD_PORTS-1:0][WIDTH-1:0]   rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rdata[p] = mem_q[raddr[p]];
    end
endmodule

// File: rtl/spiq_shifter.sv
module spiq_shifter
    import spiq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic [DIV_W-1:0]  div,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);
    sh_t q, d;

    assign sclk    = q.sclk;
    assign mosi    = q.tsr[BYTE_W-1];
    assign rx_byte = q.rsr;
    assign done    = (q.st == SH_HIGH) && (q.cnt == div) && (q.bitn == BIT_W'(BYTE_W-1));

    always_comb begin
        d = q;
        case (q.st)
            SH_IDLE: begin
                if (start) begin
                    d.st   = SH_LOW;
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.tsr  = tx_byte;
                    d.sclk = 1'b0;
                end
            end
            SH_LOW: begin
                if (q.cnt == div) begin
                    d.sclk = 1'b1;
                    d.rsr  = {q.rsr[BYTE_W-2:0], miso};
                    d.cnt  = '0;
                    d.st   = SH_HIGH;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SH_HIGH: begin
                if (q.cnt == div) begin
                    d.sclk = 1'b0;
                    d.cnt  = '0;
                    if (q.bitn == BIT_W'(BYTE_W-1)) begin
                        d.st = SH_IDLE;
                    end else begin
                        d.tsr  = {q.tsr[BYTE_W-2:0], 1'b0};
                        d.bitn = q.bitn + 1'b1;
                        d.st   = SH_LOW;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4: data out holds still for the whole high half of SCLK
    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk && $past(q.sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spiq_master.sv
module spiq_master
    import spiq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    ctl_t q, d;

    logic                           wr, win, odd, cmdsel;
    logic [PTR_W-1:0]               slot, cslot;
    logic [1:0][BYTE_W-1:0]         tx_rd;
    logic [0:0][BYTE_W-1:0]         rx_rd;
    logic [1:0][0:0]                cmd_rd;
    logic                           sh_start, sh_done;
    logic [BYTE_W-1:0]              sh_rx;
    logic                           last_w, keep_w;

    assign wr     = bus_sel & bus_wr;
    assign win    = (bus_addr[ADDR_W-1:PTR_W+1] == '0);
    assign odd    = bus_addr[0];
    assign slot   = bus_addr[PTR_W:1];
    assign cmdsel = (bus_addr[ADDR_W-1:PTR_W] == 3'b010);
    assign cslot  = bus_addr[PTR_W-1:0];

    spiq_regfile #(.DEPTH(Q_DEPTH), .WIDTH(BYTE_W), .RD_PORTS(2)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .we(wr && win && !odd && !q.en), .waddr(slot), .wdata(bus_wdata),
        .raddr({slot, q.cur}), .rdata(tx_rd)
    );

    spiq_regfile #(.DEPTH(Q_DEPTH), .WIDTH(BYTE_W), .RD_PORTS(1)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .we(sh_done), .waddr(q.cur), .wdata(sh_rx),
        .raddr(slot), .rdata(rx_rd)
    );

    spiq_regfile #(.DEPTH(Q_DEPTH), .WIDTH(1), .RD_PORTS(2)) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .we(wr && cmdsel && !q.en), .waddr(cslot), .wdata(bus_wdata[0]),
        .raddr({cslot, q.cur}), .rdata(cmd_rd)
    );

    spiq_shifter u_sh (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(tx_rd[0]),
        .div(q.div), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .done(sh_done), .rx_byte(sh_rx)
    );

    assign spi_cs_n = ~q.cs_act;

    always_comb begin
        bus_rdata = '0;
        if (win) begin
            bus_rdata = odd ? rx_rd[0] : tx_rd[1];
        end else if (cmdsel) begin
            bus_rdata = BYTE_W'(cmd_rd[1]);
        end else begin
            case (bus_addr)
                A_START: bus_rdata = BYTE_W'(q.sptr);
                A_END:   bus_rdata = BYTE_W'(q.eptr);
                A_CTRL:  bus_rdata = BYTE_W'({q.cont_after, q.en});
                A_STAT:  bus_rdata = BYTE_W'(q.done);
                A_LOCK:  bus_rdata = BYTE_W'(q.lock);
                A_DIV:   bus_rdata = q.div;
                default: bus_rdata = '0;
            endcase
        end
    end

    always_comb begin
        d        = q;
        sh_start = 1'b0;
        last_w   = (q.cur == q.eptr);
        keep_w   = cmd_rd[0][0] & (!last_w | q.cont_after | q.lock);

        if (wr && bus_addr == A_STAT && !bus_wdata[0]) d.done = 1'b0;
        if (wr && bus_addr == A_LOCK) begin
            d.lock = bus_wdata[0];
            if (!bus_wdata[0] && q.st == PH_IDLE) d.cs_act = 1'b0;
        end
        if (wr && !q.en) begin
            if (bus_addr == A_START) d.sptr = bus_wdata[PTR_W-1:0];
            if (bus_addr == A_END)   d.eptr = bus_wdata[PTR_W-1:0];
            if (bus_addr == A_DIV)   d.div  = bus_wdata;
        end

        case (q.st)
            PH_IDLE: begin
                if (wr && bus_addr == A_CTRL) begin
                    d.cont_after = bus_wdata[1];
                    if (bus_wdata[0]) begin
                        d.en     = 1'b1;
                        d.cur    = q.sptr;
                        d.cnt    = '0;
                        d.cs_act = 1'b1;
                        d.st     = q.cs_act ? PH_LAUNCH : PH_SETUP;
                    end
                end
            end
            PH_SETUP: begin
                if (q.cnt == q.div) begin
                    d.cnt = '0;
                    d.st  = PH_LAUNCH;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_LAUNCH: begin
                sh_start = 1'b1;
                d.st     = PH_XFER;
            end
            PH_XFER: begin
                if (sh_done) begin
                    if (last_w) begin
                        d.en         = 1'b0;
                        d.cont_after = 1'b0;
                        d.done       = 1'b1;
                        d.cs_act     = keep_w;
                        d.st         = PH_IDLE;
                    end else begin
                        d.cur = q.cur + 1'b1;
                        if (keep_w) begin
                            d.st = PH_LAUNCH;
                        end else begin
                            d.cs_act = 1'b0;
                            d.cnt    = '0;
                            d.st     = PH_GAP;
                        end
                    end
                end
            end
            PH_GAP: begin
                if (q.cnt == q.div) begin
                    d.cnt    = '0;
                    d.cs_act = 1'b1;
                    d.st     = PH_SETUP;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: every SCLK rising edge falls inside an asserted chip-select frame
    p_cs_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> !spi_cs_n);

    // R1: serial clock rests low while the sequencer is idle
    p_sclk_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PH_IDLE) |-> !spi_sclk);

    // R8: enable only drops together with the done flag being raised
    p_en_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.en) |-> q.done);

    // R10: pointers and divider are frozen during a run
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.en && $past(q.en)) |-> ($stable(q.sptr) && $stable(q.eptr) && $stable(q.div)));
endmodule

// File: tb/spiq_master_tb_top.sv
module spiq_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] R_START = 7'h30, R_END = 7'h31, R_CTRL = 7'h32,
                           R_STAT = 7'h33, R_LOCK = 7'h34, R_DIV = 7'h35;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [6:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic spi_sclk, spi_mosi, spi_miso, spi_cs_n;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] sbytes [64];
    logic [7:0] capb [64];
    logic [9:0] bidx = '0;
    int cs_rise = 0, cs_fall = 0;
    logic [7:0] tx_b [16];
    logic       cont_b [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    spiq_master dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // slave model: streams sbytes MSB first, captures MOSI on rising SCLK
    assign spi_miso = sbytes[bidx[8:3]][3'd7 - bidx[2:0]];
    always @(posedge spi_sclk) begin
        capb[bidx[8:3]] = {capb[bidx[8:3]][6:0], spi_mosi};
        bidx = bidx + 10'd1;
    end
    always @(posedge spi_cs_n) cs_rise++;
    always @(negedge spi_cs_n) cs_fall++;

    task automatic chk_eq(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [7:0] v);
        bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        logic [7:0] v;
        do begin
            @(negedge clk);
            rd_reg(R_CTRL, v);
            guard++;
        end while (v[0] && guard < 20000);
        chk_eq("R8 run finishes", int'(guard < 20000), 1);
    endtask

    function automatic int run_len(input int sp, input int ep);
        return ((ep - sp) & 15) + 1;
    endfunction

    task automatic load_entries();
        for (int e = 0; e < 16; e++) begin
            tx_b[e]   = 8'($urandom);
            cont_b[e] = 1'($urandom);
            wr_reg(7'(2*e), tx_b[e]);
            wr_reg(7'(32+e), {7'b0, cont_b[e]});
        end
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] keep4;
        int t_done;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 64; i++) begin sbytes[i] = 8'($urandom); capb[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_eq("R1 cs_n", int'(spi_cs_n), 1);
        chk_eq("R1 sclk", int'(spi_sclk), 0);
        rd_reg(R_CTRL, v);  chk_eq("R1 ctrl", v, 0);
        rd_reg(R_STAT, v);  chk_eq("R1 status", v, 0);
        rd_reg(R_START, v); chk_eq("R1 start ptr", v, 0);
        rd_reg(R_END, v);   chk_eq("R1 end ptr", v, 0);
        rd_reg(R_DIV, v);   chk_eq("R1 divider", v, 0);

        // random runs: R2 R3 R4 R5 R6 R8 R9
        for (int it = 0; it < 6; it++) begin
            int dv, sp, ep, n, exp_r;
            dv = $urandom % 3; sp = $urandom % 16; ep = $urandom % 16;
            wr_reg(R_DIV, 8'(dv)); wr_reg(R_START, 8'(sp)); wr_reg(R_END, 8'(ep));
            load_entries();
            rd_reg(7'(2*sp), v);  chk_eq("R2 tx word readback", v, tx_b[sp]);
            rd_reg(7'(32+sp), v); chk_eq("R2 cmd word readback", v, int'(cont_b[sp]));
            for (int i = 0; i < 64; i++) sbytes[i] = 8'($urandom);
            bidx = '0; cs_rise = 0; cs_fall = 0;
            wr_reg(R_CTRL, 8'h01);
            wait_idle();
            n = run_len(sp, ep);
            exp_r = 1;
            for (int j = 0; j < n - 1; j++) if (!cont_b[(sp + j) & 15]) exp_r++;
            for (int j = 0; j < n; j++) begin
                int e;
                e = (sp + j) & 15;
                chk_eq("R3 R4 MOSI byte order", capb[j], tx_b[e]);
                rd_reg(7'(2*e + 1), v);
                chk_eq("R4 received byte", v, sbytes[j]);
            end
            chk_eq("R4 SCLK rises", int'(bidx), 8*n);
            chk_eq("R5 CS releases", cs_rise, exp_r);
            chk_eq("R5 CS frames", cs_fall, exp_r);
            chk_eq("R6 CS released at end", int'(spi_cs_n), 1);
            rd_reg(R_STAT, v); chk_eq("R8 done set", v, 1);
            wr_reg(R_STAT, 8'h00);
            rd_reg(R_STAT, v); chk_eq("R9 done cleared", v, 0);
        end

        // hold-after-run then continuation run: R6 R8
        wr_reg(R_DIV, 8'd1);
        wr_reg(7'h20, 8'h01); wr_reg(7'h21, 8'h01); wr_reg(7'h22, 8'h00);
        wr_reg(R_START, 8'd0); wr_reg(R_END, 8'd1);
        bidx = '0;
        wr_reg(R_CTRL, 8'h03);
        wait_idle();
        chk_eq("R6 CS held after run", int'(spi_cs_n), 0);
        rd_reg(R_CTRL, v); chk_eq("R8 ctrl bits cleared", v, 0);
        wr_reg(R_STAT, 8'h00);
        cs_rise = 0; cs_fall = 0;
        wr_reg(R_START, 8'd2); wr_reg(R_END, 8'd2);
        wr_reg(R_CTRL, 8'h01);
        wait_idle();
        chk_eq("R6 no new frame start", cs_fall, 0);
        chk_eq("R6 single release", cs_rise, 1);
        chk_eq("R3 continued byte", capb[2], tx_b[2]);
        wr_reg(R_STAT, 8'h00);

        // lock holds frame, lock clear releases: R6 R7
        wr_reg(R_LOCK, 8'h01);
        wr_reg(7'h23, 8'h01);
        wr_reg(R_START, 8'd3); wr_reg(R_END, 8'd3);
        wr_reg(R_CTRL, 8'h01);
        wait_idle();
        chk_eq("R6 CS held by lock", int'(spi_cs_n), 0);
        rd_reg(R_LOCK, v); chk_eq("R2 lock readback", v, 1);
        wr_reg(R_LOCK, 8'h00);
        chk_eq("R7 lock clear releases CS", int'(spi_cs_n), 1);
        wr_reg(R_STAT, 8'h00);

        // writes while busy are ignored: R10
        wr_reg(R_DIV, 8'd3);
        wr_reg(7'h27, 8'h00);
        rd_reg(7'd8, keep4);
        wr_reg(R_START, 8'd4); wr_reg(R_END, 8'd7);
        wr_reg(R_CTRL, 8'h01);
        wr_reg(7'd8, ~keep4);
        wr_reg(R_START, 8'd9);
        wr_reg(R_DIV, 8'd0);
        wr_reg(7'h24, 8'h01);
        wr_reg(R_CTRL, 8'h00);
        wait_idle();
        rd_reg(7'd8, v);    chk_eq("R10 tx byte kept", v, keep4);
        rd_reg(R_START, v); chk_eq("R10 start ptr kept", v, 4);
        rd_reg(R_DIV, v);   chk_eq("R10 divider kept", v, 3);
        rd_reg(R_STAT, v);  chk_eq("R10 run not aborted", v, 1);
        chk_eq("R6 CS released after run", int'(spi_cs_n), 1);
        wr_reg(R_STAT, 8'h00);
        wr_reg(R_STAT, 8'h01);
        rd_reg(R_STAT, v);  chk_eq("R9 writing one has no effect", v, 0);

        // completion and clear on the same edge: R9 R11
        wr_reg(R_DIV, 8'd2);
        wr_reg(7'h25, 8'h00);
        wr_reg(R_START, 8'd5); wr_reg(R_END, 8'd5);
        t_done = 17 * 3 + 1;
        wr_reg(R_CTRL, 8'h01);
        repeat (t_done - 1) @(negedge clk);
        rd_reg(R_STAT, v); chk_eq("R11 done not yet set", v, 0);
        rd_reg(R_CTRL, v); chk_eq("R11 still enabled", v, 1);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = R_STAT; bus_wdata = 8'h00;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd_reg(R_STAT, v); chk_eq("R9 set wins over clear", v, 1);
        rd_reg(R_CTRL, v); chk_eq("R11 enable dropped on time", v, 0);
        wr_reg(R_STAT, 8'h00);
        rd_reg(R_STAT, v); chk_eq("R9 later clear", v, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule